// File: doc/BRIEF.md
# Home Directory Controller with Relocated-Home Forwarding

This block is the coherence controller at a cache line's default home node in a 16-core mesh. It holds a small direct-mapped table of per-line sharer vectors and a second direct-mapped table of redirections. A redirection records which core now holds a line's directory entry after ownership has moved to a producer core. Requests arrive one at a time as abstract records carrying a source core, a kind and a line address. The controller answers each request with a short, ordered run of outgoing records: forwards, invalidates, producer reads, responses, memory requests and fetches of the directory entry from the upper level.

Reads that hit the directory are forwarded to a recorded sharer, and the requester is then answered. Writes invalidate every other sharer and hand the prior sharer vector to the writer, and the line stays busy until the writer acknowledges. A request that misses the directory but finds a redirection goes straight to the core named in it. A request that misses both tables waits for the entry to come back from the upper level. While a line is busy, one further read or write to it is parked and is replayed once the line clears.

Top module: `hd_home_directory`

## Requirements
- R1: A read (in_type 0) that hits the directory with a non-empty sharer set emits a forward (out_type 0) to the lowest-numbered sharer, carrying the sharer vector in out_vec. It then emits a read response (out_type 3) to the requester and adds the requester to the sharer set.
- R2: A read that misses the directory but hits the forwarding table emits one read-producer record (out_type 2) to the recorded core, with out_req naming the requester.
- R3: A read or write that misses both tables emits a fetch (out_type 5) and then waits for a fill (in_type 5) whose in_vec becomes the entry's sharer set. After that the request proceeds as a directory hit. An empty fill first emits a memory request (out_type 6), followed by the response (read) or the entry hand-over (write).
- R4: A write (in_type 1) that hits the directory emits an invalidate (out_type 1) to every sharer other than the requester, in ascending core order. It then emits the entry hand-over (out_type 4) with the prior sharer vector to the requester. The entry then holds only the requester and is busy.
- R5: A write that misses the directory but hits the forwarding table emits a write forward (out_type 7) to the recorded core and rewrites the forwarding entry to name the requester.
- R6: An update-home record (in_type 2) writes the forwarding entry for its line with the sender, replacing any older value.
- R7: A writeback or replacement notice (in_type 4) clears the sender's bit in the line's sharer set.
- R8: While a line is busy, a read or write to it is held in a one-entry stall buffer and produces no output. A second such request is refused (in_ready low). An acknowledgement (in_type 3) to the line clears busy, and the held request is then replayed.
- R9: Both tables are direct-mapped on the low address bits with a stored tag. Allocating a line evicts the line at the same index, and the evicted line then misses.
- R10: While out_valid is high and out_ready is low, out_valid and every output field hold their values.
- R11: After reset no output is pending, both tables are empty and in_ready is high.
- R12: in_ready is never high while an output is pending. While waiting for a fill, only a fill is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming record present |
| in_ready | output | 1 | Incoming record accepted this cycle |
| in_src | input | 4 | Sending core |
| in_type | input | 3 | Incoming kind (0 read, 1 write, 2 update-home, 3 ack, 4 writeback, 5 fill) |
| in_addr | input | ADDR_W | Line address |
| in_vec | input | 16 | Sharer vector carried by a fill |
| out_valid | output | 1 | Outgoing record present |
| out_ready | input | 1 | Outgoing record taken this cycle |
| out_type | output | 3 | Outgoing kind (0 forward, 1 invalidate, 2 read-producer, 3 response, 4 entry hand-over, 5 fetch, 6 memory request, 7 write forward) |
| out_dst | output | 4 | Destination core |
| out_req | output | 4 | Original requester |
| out_addr | output | ADDR_W | Line address |
| out_vec | output | 16 | Sharer vector for forward, invalidate and hand-over |

## Verification
The bench targets the points where a controller of this kind goes wrong. A write must not invalidate its own requester, and it must invalidate the other sharers in ascending order; a faulty design would emit a self-invalidate or skip a sharer. An empty fill must trigger a memory request; a faulty design would answer with no data source. A request parked behind a busy line must wait and replay only after the acknowledgement; a faulty design would answer early or lose the request. The bench also checks that a write forward really moves the forwarding entry, that an index collision evicts the older line in each table, and that outputs hold still under back-pressure.

// File: rtl/hd_pkg.sv
// Shared encodings for the home directory controller.
// Assumes a 3-bit message kind field on both the input and the output side.
package hd_pkg;

    typedef enum logic [2:0] {
        IN_RD   = 3'd0,
        IN_WR   = 3'd1,
        IN_UPD  = 3'd2,
        IN_ACK  = 3'd3,
        IN_WB   = 3'd4,
        IN_FILL = 3'd5
    } in_kind_e;

    typedef enum logic [2:0] {
        OUT_FWD    = 3'd0,
        OUT_INV    = 3'd1,
        OUT_RDP    = 3'd2,
        OUT_RESP   = 3'd3,
        OUT_DIRENT = 3'd4,
        OUT_FETCH  = 3'd5,
        OUT_MEM    = 3'd6,
        OUT_WFWD   = 3'd7
    } out_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DECIDE,
        S_FWD,
        S_MEM,
        S_RESP,
        S_INV,
        S_DIRENT,
        S_RDP,
        S_WFWD,
        S_FETCH,
        S_WAIT
    } ctl_state_e;

endpackage

// File: rtl/hd_dm_table.sv
// Direct-mapped tagged table with NRD combinational read ports and one write port.
// A write allocates: it overwrites whatever line occupied the same index.
// Assumes IDX_W < ADDR_W.
module hd_dm_table #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 17,
    parameter int NRD    = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD*ADDR_W-1:0]   rd_addr,
    output logic [NRD-1:0]          rd_hit,
    output logic [NRD*DATA_W-1:0]   rd_data,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              vld_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];

    logic [IDX_W-1:0]  wr_idx;
    assign wr_idx = wr_addr[IDX_W-1:0];

    // Storage update: clear on reset, allocate or rewrite on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_addr[ADDR_W-1:IDX_W];
            dat_q[wr_idx] <= wr_data;
        end
    end

    // One tag compare per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [ADDR_W-1:0] a;
        logic [IDX_W-1:0]  ix;
        assign a  = rd_addr[p*ADDR_W +: ADDR_W];
        assign ix = a[IDX_W-1:0];
        assign rd_hit[p] = vld_q[ix] && (tag_q[ix] == a[ADDR_W-1:IDX_W]);
        assign rd_data[p*DATA_W +: DATA_W] = dat_q[ix];
    end

endmodule

// File: rtl/hd_lowest_one.sv
// Index of the lowest set bit of a vector; zero when the vector is empty.
// Used to walk sharer sets in ascending core order.
module hd_lowest_one #(
    parameter int W   = 16,
    parameter int IDW = 4
) (
    input  logic [W-1:0]   vec,
    output logic [IDW-1:0] idx
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDW'(i);
        end
    end
endmodule

// File: rtl/hd_stall_buf.sv
// One-entry holding register for a request that arrived while its line was busy.
// Assumes the producer never pushes while the entry is full.
module hd_stall_buf #(
    parameter int ADDR_W = 12,
    parameter int CORE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [CORE_W-1:0] push_src,
    input  logic [2:0]        push_kind,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              full,
    output logic [CORE_W-1:0] hold_src,
    output logic [2:0]        hold_kind,
    output logic [ADDR_W-1:0] hold_addr
);
    // Occupancy and payload of the single slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            hold_src  <= '0;
            hold_kind <= '0;
            hold_addr <= '0;
        end else if (push) begin
            full      <= 1'b1;
            hold_src  <= push_src;
            hold_kind <= push_kind;
            hold_addr <= push_addr;
        end else if (pop) begin
            full      <= 1'b0;
        end
    end
endmodule

// File: rtl/hd_home_directory.sv
// Directory controller at a line's default home node.
// Serves one request at a time and emits its outgoing records one per handshake.
// Port 0 of the directory table looks up the held request, port 1 the incoming
// record and port 2 the parked request. Assumes a single requester per record
// and an upper level that always answers a fetch with a fill.
module hd_home_directory
    import hd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NCORE     = 16,
    parameter int DIR_IDX_W = 3,
    parameter int FWD_IDX_W = 3,
    localparam int CORE_W   = $clog2(NCORE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CORE_W-1:0] in_src,
    input  logic [2:0]        in_type,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [NCORE-1:0]  in_vec,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_type,
    output logic [CORE_W-1:0] out_dst,
    output logic [CORE_W-1:0] out_req,
    output logic [ADDR_W-1:0] out_addr,
    output logic [NCORE-1:0]  out_vec
);
    localparam int DIR_DW  = NCORE + 1;
    localparam int DIR_NRD = 3;
    localparam logic [NCORE-1:0] ONE = NCORE'(1);

    ctl_state_e        st;
    logic [CORE_W-1:0] r_src;
    logic [2:0]        r_type;
    logic [ADDR_W-1:0] r_addr;
    logic [NCORE-1:0]  r_vec;
    logic [NCORE-1:0]  r_pend;
    logic [CORE_W-1:0] r_prod;

    logic [DIR_NRD-1:0]        dir_hit;
    logic [DIR_NRD*DIR_DW-1:0] dir_data;
    logic                      dir_we;
    logic [ADDR_W-1:0]         dir_waddr;
    logic [DIR_DW-1:0]         dir_wdata;

    logic              fwd_hit;
    logic [CORE_W-1:0] fwd_core;
    logic              fwd_we;
    logic [ADDR_W-1:0] fwd_waddr;
    logic [CORE_W-1:0] fwd_wdata;

    logic              stall_full, stall_push, stall_pop;
    logic [CORE_W-1:0] stall_src;
    logic [2:0]        stall_kind;
    logic [ADDR_W-1:0] stall_addr;

    logic [NCORE-1:0]  low_in;
    logic [CORE_W-1:0] low_idx;

    logic [NCORE-1:0] vec0, vec1;
    logic             busy1, busy2;
    logic             dir_unused;
    logic             in_rdwr, in_busy, replay, acc_in, r_is_rd;
    logic [NCORE-1:0] pend_next;

    assign vec0       = dir_data[NCORE-1:0];
    assign vec1       = dir_data[DIR_DW +: NCORE];
    assign busy1      = dir_data[2*DIR_DW-1];
    assign busy2      = dir_data[3*DIR_DW-1];
    assign dir_unused = ^{dir_data[DIR_DW-1], dir_data[2*DIR_DW +: NCORE]};

    assign in_rdwr   = (in_type == IN_RD) || (in_type == IN_WR);
    assign in_busy   = dir_hit[1] && busy1;
    assign replay    = stall_full && !(dir_hit[2] && busy2);
    assign acc_in    = in_valid && in_ready;
    assign r_is_rd   = (r_type == IN_RD);
    assign pend_next = r_pend & ~(ONE << low_idx);

    hd_dm_table #(.ADDR_W(ADDR_W), .IDX_W(DIR_IDX_W), .DATA_W(DIR_DW), .NRD(DIR_NRD)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_addr({stall_addr, in_addr, r_addr}),
        .rd_hit(dir_hit), .rd_data(dir_data),
        .wr_en(dir_we), .wr_addr(dir_waddr), .wr_data(dir_wdata)
    );

    hd_dm_table #(.ADDR_W(ADDR_W), .IDX_W(FWD_IDX_W), .DATA_W(CORE_W), .NRD(1)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(r_addr), .rd_hit(fwd_hit), .rd_data(fwd_core),
        .wr_en(fwd_we), .wr_addr(fwd_waddr), .wr_data(fwd_wdata)
    );

    hd_stall_buf #(.ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_stall (
        .clk(clk), .rst_n(rst_n),
        .push(stall_push), .pop(stall_pop),
        .push_src(in_src), .push_kind(in_type), .push_addr(in_addr),
        .full(stall_full),
        .hold_src(stall_src), .hold_kind(stall_kind), .hold_addr(stall_addr)
    );

    assign low_in = (st == S_INV) ? r_pend : r_vec;

    hd_lowest_one #(.W(NCORE), .IDW(CORE_W)) u_low (
        .vec(low_in), .idx(low_idx)
    );

    // Input acceptance: idle takes anything except a second request to a busy
    // line; the fill wait takes only a fill.
    always_comb begin
        in_ready = 1'b0;
        if (st == S_IDLE) begin
            in_ready = !replay && !(in_rdwr && in_busy && stall_full);
        end else if (st == S_WAIT) begin
            in_ready = (in_type == IN_FILL);
        end
    end

    assign stall_push = (st == S_IDLE) && acc_in && in_rdwr && in_busy;
    assign stall_pop  = (st == S_IDLE) && replay;

    // Directory table writes: sharer removal, busy release, fill, read join, write grant.
    always_comb begin
        dir_we    = 1'b0;
        dir_waddr = r_addr;
        dir_wdata = '0;
        unique case (st)
            S_IDLE: begin
                if (acc_in && dir_hit[1] && (in_type == IN_WB)) begin
                    dir_we    = 1'b1;
                    dir_waddr = in_addr;
                    dir_wdata = {busy1, vec1 & ~(ONE << in_src)};
                end else if (acc_in && dir_hit[1] && (in_type == IN_ACK)) begin
                    dir_we    = 1'b1;
                    dir_waddr = in_addr;
                    dir_wdata = {1'b0, vec1};
                end
            end
            S_WAIT: begin
                if (in_valid && (in_type == IN_FILL)) begin
                    dir_we    = 1'b1;
                    dir_wdata = {1'b0, in_vec};
                end
            end
            S_RESP: begin
                dir_we    = out_ready;
                dir_wdata = {1'b0, r_vec | (ONE << r_src)};
            end
            S_DIRENT: begin
                dir_we    = out_ready;
                dir_wdata = {1'b1, ONE << r_src};
            end
            default: ;
        endcase
    end

    // Forwarding table writes: update-home from any core, or write forward re-pointing.
    always_comb begin
        fwd_we    = 1'b0;
        fwd_waddr = r_addr;
        fwd_wdata = r_src;
        if ((st == S_IDLE) && acc_in && (in_type == IN_UPD)) begin
            fwd_we    = 1'b1;
            fwd_waddr = in_addr;
            fwd_wdata = in_src;
        end else if ((st == S_WFWD) && out_ready) begin
            fwd_we    = 1'b1;
        end
    end

    // Sequencer: load a request, classify it, then step through its outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            r_src  <= '0;
            r_type <= '0;
            r_addr <= '0;
            r_vec  <= '0;
            r_pend <= '0;
            r_prod <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (replay) begin
                        r_src  <= stall_src;
                        r_type <= stall_kind;
                        r_addr <= stall_addr;
                        st     <= S_DECIDE;
                    end else if (acc_in && in_rdwr && !in_busy) begin
                        r_src  <= in_src;
                        r_type <= in_type;
                        r_addr <= in_addr;
                        st     <= S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    r_vec  <= vec0;
                    r_pend <= vec0 & ~(ONE << r_src);
                    r_prod <= fwd_core;
                    if (dir_hit[0]) begin
                        if (vec0 == '0)         st <= S_MEM;
                        else if (r_is_rd)       st <= S_FWD;
                        else if ((vec0 & ~(ONE << r_src)) != '0) st <= S_INV;
                        else                    st <= S_DIRENT;
                    end else if (fwd_hit) begin
                        st <= r_is_rd ? S_RDP : S_WFWD;
                    end else begin
                        st <= S_FETCH;
                    end
                end
                S_FWD:    if (out_ready) st <= S_RESP;
                S_MEM:    if (out_ready) st <= r_is_rd ? S_RESP : S_DIRENT;
                S_INV: begin
                    if (out_ready) begin
                        r_pend <= pend_next;
                        if (pend_next == '0) st <= S_DIRENT;
                    end
                end
                S_RESP, S_DIRENT, S_RDP, S_WFWD: if (out_ready) st <= S_IDLE;
                S_FETCH:  if (out_ready) st <= S_WAIT;
                S_WAIT:   if (in_valid && (in_type == IN_FILL)) st <= S_DECIDE;
                default:  st <= S_IDLE;
            endcase
        end
    end

    // Output record decoded from the sequencer state.
    always_comb begin
        out_valid = 1'b1;
        out_type  = OUT_RESP;
        out_dst   = r_src;
        out_req   = r_src;
        out_addr  = r_addr;
        out_vec   = '0;
        unique case (st)
            S_FWD:    begin out_type = OUT_FWD;    out_dst = low_idx; out_vec = r_vec; end
            S_INV:    begin out_type = OUT_INV;    out_dst = low_idx; out_vec = r_vec; end
            S_DIRENT: begin out_type = OUT_DIRENT; out_vec = r_vec; end
            S_RESP:   out_type = OUT_RESP;
            S_MEM:    out_type = OUT_MEM;
            S_FETCH:  out_type = OUT_FETCH;
            S_RDP:    begin out_type = OUT_RDP;  out_dst = r_prod; end
            S_WFWD:   begin out_type = OUT_WFWD; out_dst = r_prod; end
            default:  out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/hd_home_directory_chk.sv
// Protocol checker for the home directory controller, bound to its top module.
module hd_home_directory_chk
    import hd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCORE  = 16,
    localparam int CORE_W = $clog2(NCORE)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_type,
    input logic [CORE_W-1:0] out_dst,
    input logic [CORE_W-1:0] out_req,
    input logic [ADDR_W-1:0] out_addr,
    input logic [NCORE-1:0]  out_vec
);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst)
                                    && $stable(out_req) && $stable(out_addr) && $stable(out_vec));

    // R12
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R4
    inv_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_type == OUT_INV) |-> (out_dst != out_req) && out_vec[out_dst]);

    // R1
    fwd_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_type == OUT_FWD) |-> out_vec[out_dst]);

    // R3
    fetch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && (out_type == OUT_FETCH) |=> !out_valid);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind hd_home_directory hd_home_directory_chk #(.ADDR_W(ADDR_W), .NCORE(NCORE)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_dst(out_dst), .out_req(out_req), .out_addr(out_addr), .out_vec(out_vec)
);

// File: tb/tb_hd_home_directory.sv
// Scoreboard bench: the driver queues expected records, a monitor checks them.
module tb_hd_home_directory;
    localparam logic [2:0] T_RD = 3'd0, T_WR = 3'd1, T_UPD = 3'd2, T_ACK = 3'd3,
                           T_WB = 3'd4, T_FILL = 3'd5;
    localparam logic [2:0] O_FWD = 3'd0, O_INV = 3'd1, O_RDP = 3'd2, O_RESP = 3'd3,
                           O_DIRENT = 3'd4, O_FETCH = 3'd5, O_MEM = 3'd6, O_WFWD = 3'd7;
    localparam logic [11:0] LA = 12'h010, LB = 12'h021, LC = 12'h032, LD = 12'h03A,
                            LE = 12'h018, LF = 12'h044;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_src = '0;
    logic [2:0]  in_type = '0;
    logic [11:0] in_addr = '0;
    logic [15:0] in_vec = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_type;
    logic [3:0]  out_dst, out_req;
    logic [11:0] out_addr;
    logic [15:0] out_vec;

    always #2 clk = ~clk;

    hd_home_directory dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_type(in_type),
        .in_addr(in_addr), .in_vec(in_vec),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
        .out_dst(out_dst), .out_req(out_req), .out_addr(out_addr), .out_vec(out_vec)
    );

    typedef struct {
        logic [2:0]  t;
        logic [3:0]  dst;
        logic [3:0]  req;
        logic [11:0] addr;
        logic [15:0] vec;
        bit          cv;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    task automatic expect_out(logic [2:0] t, logic [3:0] dst, logic [3:0] req,
                              logic [11:0] a, logic [15:0] v, bit cv, string tag);
        exp_t e;
        e.t = t; e.dst = dst; e.req = req; e.addr = a; e.vec = v; e.cv = cv; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Monitor: a record present at the falling edge with ready high is taken next edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "any", "unexpected record type", int'(out_type), 0);
            end else begin
                exp_t e;
                bit ok;
                e = q.pop_front();
                ok = (out_type == e.t) && (out_dst == e.dst) && (out_req == e.req)
                     && (out_addr == e.addr) && (!e.cv || (out_vec == e.vec));
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s record: actual t%0d d%0d r%0d a%0h v%0h expected t%0d d%0d r%0d a%0h v%0h",
                             e.tag, out_type, out_dst, out_req, out_addr, out_vec,
                             e.t, e.dst, e.req, e.addr, e.vec);
                end
            end
        end
    end

    task automatic send(logic [2:0] t, logic [3:0] s, logic [11:0] a, logic [15:0] v);
        @(negedge clk);
        in_valid = 1'b1; in_type = t; in_src = s; in_addr = a; in_vec = v;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic probe_ready(logic [2:0] t, logic [3:0] s, logic [11:0] a,
                               bit expv, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_type = t; in_src = s; in_addr = a; in_vec = '0;
        #1;
        chk(in_ready == expv, tag, "in_ready", int'(in_ready), int'(expv));
        in_valid = 1'b0;
    endtask

    task automatic drain(string tag);
        int n = 0;
        while ((q.size() != 0 || out_valid) && n < 200) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(q.size() == 0, tag, "records still owed", q.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);

        // R3: empty tables, empty fill -> fetch, memory request, response
        expect_out(O_FETCH, 4'd2, 4'd2, LA, 16'h0, 0, "R3");
        send(T_RD, 4'd2, LA, 16'h0);
        drain("R3");
        probe_ready(T_RD, 4'd7, LA, 1'b0, "R12");
        expect_out(O_MEM, 4'd2, 4'd2, LA, 16'h0, 0, "R3");
        expect_out(O_RESP, 4'd2, 4'd2, LA, 16'h0, 0, "R3");
        send(T_FILL, 4'd0, LA, 16'h0);
        drain("R3");

        // R1: read hit forwards to the sharer, then responds
        expect_out(O_FWD, 4'd2, 4'd5, LA, 16'h0004, 1, "R1");
        expect_out(O_RESP, 4'd5, 4'd5, LA, 16'h0, 0, "R1");
        send(T_RD, 4'd5, LA, 16'h0);
        drain("R1");

        // R7: writeback drops core 2; the hand-over vector below shows only core 5
        send(T_WB, 4'd2, LA, 16'h0);
        expect_out(O_INV, 4'd5, 4'd9, LA, 16'h0020, 1, "R4");
        expect_out(O_DIRENT, 4'd9, 4'd9, LA, 16'h0020, 1, "R7");
        send(T_WR, 4'd9, LA, 16'h0);
        drain("R4");

        // R8: read to busy line parks, second is refused, ack releases replay
        send(T_RD, 4'd3, LA, 16'h0);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R8", "output while parked", int'(out_valid), 0);
        probe_ready(T_RD, 4'd4, LA, 1'b0, "R8");
        expect_out(O_FWD, 4'd9, 4'd3, LA, 16'h0200, 1, "R8");
        expect_out(O_RESP, 4'd3, 4'd3, LA, 16'h0, 0, "R8");
        send(T_ACK, 4'd9, LA, 16'h0);
        drain("R8");

        // R4: writer already a sharer is not invalidated
        expect_out(O_INV, 4'd9, 4'd3, LA, 16'h0208, 1, "R4");
        expect_out(O_DIRENT, 4'd3, 4'd3, LA, 16'h0208, 1, "R4");
        send(T_WR, 4'd3, LA, 16'h0);
        drain("R4");
        send(T_ACK, 4'd3, LA, 16'h0);

        // R3 non-empty fill, then R4 ascending invalidates
        expect_out(O_FETCH, 4'd1, 4'd1, LB, 16'h0, 0, "R3");
        send(T_RD, 4'd1, LB, 16'h0);
        drain("R3");
        expect_out(O_FWD, 4'd0, 4'd1, LB, 16'h8011, 1, "R3");
        expect_out(O_RESP, 4'd1, 4'd1, LB, 16'h0, 0, "R3");
        send(T_FILL, 4'd0, LB, 16'h8011);
        drain("R3");
        expect_out(O_INV, 4'd0, 4'd4, LB, 16'h8013, 1, "R4");
        expect_out(O_INV, 4'd1, 4'd4, LB, 16'h8013, 1, "R4");
        expect_out(O_INV, 4'd15, 4'd4, LB, 16'h8013, 1, "R4");
        expect_out(O_DIRENT, 4'd4, 4'd4, LB, 16'h8013, 1, "R4");
        send(T_WR, 4'd4, LB, 16'h0);
        drain("R4");
        send(T_ACK, 4'd4, LB, 16'h0);

        // R6 and R2: update-home then read goes to the new home
        send(T_UPD, 4'd7, LC, 16'h0);
        expect_out(O_RDP, 4'd7, 4'd6, LC, 16'h0, 0, "R2");
        send(T_RD, 4'd6, LC, 16'h0);
        drain("R6");

        // R5: write forward re-points the entry to the writer
        expect_out(O_WFWD, 4'd7, 4'd8, LC, 16'h0, 0, "R5");
        send(T_WR, 4'd8, LC, 16'h0);
        drain("R5");
        expect_out(O_RDP, 4'd8, 4'd1, LC, 16'h0, 0, "R5");
        send(T_RD, 4'd1, LC, 16'h0);
        drain("R5");

        // R9: forwarding eviction at the same index
        send(T_UPD, 4'd11, LD, 16'h0);
        expect_out(O_FETCH, 4'd0, 4'd0, LC, 16'h0, 0, "R9");
        send(T_RD, 4'd0, LC, 16'h0);
        drain("R9");
        expect_out(O_FWD, 4'd2, 4'd0, LC, 16'h0004, 1, "R9");
        expect_out(O_RESP, 4'd0, 4'd0, LC, 16'h0, 0, "R9");
        send(T_FILL, 4'd0, LC, 16'h0004);
        drain("R9");
        expect_out(O_RDP, 4'd11, 4'd6, LD, 16'h0, 0, "R6");
        send(T_RD, 4'd6, LD, 16'h0);
        drain("R6");

        // R9: directory eviction, the older line must be fetched again
        expect_out(O_FETCH, 4'd5, 4'd5, LE, 16'h0, 0, "R9");
        send(T_RD, 4'd5, LE, 16'h0);
        drain("R9");
        expect_out(O_FWD, 4'd1, 4'd5, LE, 16'h0002, 1, "R9");
        expect_out(O_RESP, 4'd5, 4'd5, LE, 16'h0, 0, "R9");
        send(T_FILL, 4'd0, LE, 16'h0002);
        drain("R9");
        expect_out(O_FETCH, 4'd6, 4'd6, LA, 16'h0, 0, "R9");
        send(T_RD, 4'd6, LA, 16'h0);
        drain("R9");
        expect_out(O_MEM, 4'd6, 4'd6, LA, 16'h0, 0, "R9");
        expect_out(O_RESP, 4'd6, 4'd6, LA, 16'h0, 0, "R9");
        send(T_FILL, 4'd0, LA, 16'h0);
        drain("R9");

        // R10: back-pressure holds the forward record
        @(posedge clk); #1 out_ready = 1'b0;
        expect_out(O_FWD, 4'd6, 4'd2, LA, 16'h0040, 1, "R10");
        expect_out(O_RESP, 4'd2, 4'd2, LA, 16'h0, 0, "R10");
        send(T_RD, 4'd2, LA, 16'h0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(out_valid && (out_type == O_FWD) && (out_dst == 4'd6), "R10",
                "held forward", int'(out_type), int'(O_FWD));
        end
        @(posedge clk); #1 out_ready = 1'b1;
        drain("R10");

        // R3: write missing both tables with an empty fill
        expect_out(O_FETCH, 4'd12, 4'd12, LF, 16'h0, 0, "R3");
        send(T_WR, 4'd12, LF, 16'h0);
        drain("R3");
        expect_out(O_MEM, 4'd12, 4'd12, LF, 16'h0, 0, "R3");
        expect_out(O_DIRENT, 4'd12, 4'd12, LF, 16'h0, 1, "R3");
        send(T_FILL, 4'd0, LF, 16'h0);
        drain("R3");
        send(T_ACK, 4'd12, LF, 16'h0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule